// File: doc/BRIEF.md
# Indirect-Access Vectored Interrupt Controller

This block gathers up to 128 interrupt request lines and drives a single interrupt line to the processor. Every source has its own enable bit, pending bit, 3-bit priority, trigger type and vector word. Software does not reach these settings through a bank of per-source registers. It first writes a source number into a select register. The mode, vector, enable, disable, set and clear accesses that follow all act on that one source.

When the processor takes the interrupt, it reads the interrupt-vector register. The read returns the vector of the winning source and records the source as the current interrupt. The source's priority goes onto an eight-level nesting stack. While the stack holds entries, only a source with a priority strictly above the top entry can raise the processor line again. Each end-of-interrupt write pops one level. A vector read that finds no candidate returns a programmable spurious word and changes no state.

The controller sits on a simple 32-bit register bus. There is one request per cycle, writes take effect at the clock edge, and read data appears on the cycle after the request.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, every source is disabled and not pending, the nesting stack is empty, `irq_o` is low, and status, mask and spurious word all read 0.
- R2: Select (0x00) holds a 7-bit source number. Mode, source vector, mask, enable, disable, set and clear touch only the selected source.
- R3: Writing a value with bit 0 set to 0x40 enables the selected source, and writing one to 0x44 disables it. Mask (0x30) returns that source's enable in bit 0. A disabled source never drives `irq_o`.
- R4: Writing bit 0 set to 0x4C makes the selected source pending, and writing one to 0x48 clears its pending bit. A source that is pending while disabled raises `irq_o` as soon as it is enabled.
- R5: Mode (0x04) keeps priority in bits [2:0] and trigger type in bit 4 (1 = rising edge, 0 = high level). Its other bits read 0. Source vector (0x08) holds a 32-bit word. Both are read back per source.
- R6: Among enabled pending sources, the highest priority wins, and on equal priority the lower source number wins.
- R7: A read of 0x10 with a candidate returns the winner's vector and pushes it onto the stack. Status (0x18) then reads bit 31 = 1 and bits [6:0] = the current source. Status reads 0 when the stack is empty.
- R8: A read of 0x10 with no candidate returns the spurious word (0x3C, read/write) and leaves the stack unchanged.
- R9: `irq_o` is high when the stack is empty and a candidate exists, or when the candidate's priority is strictly above the stack top. Each write to 0x38 pops one level, and status then shows the interrupt underneath.
- R10: An edge source becomes pending on a rising input, and reading its vector clears the pending bit. A level source is pending while its input is high or a set command is held, and the vector read clears only the set command.
- R11: The stack is eight levels deep. Eight end-of-interrupt writes empty it from any state, and an end-of-interrupt write to an empty stack changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 128 | Interrupt request lines, synchronous to `clk_i` |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach from the ports is a stack filled to all eight levels with a low-priority source still pending underneath. Only then does `irq_o` stay low across seven pops and rise exactly on the eighth. The bench reaches this state by programming eight sources with priorities 0 through 7 and taking them one at a time, in rising order, through vector reads. It then sets the priority-0 source pending again and unwinds the stack, checking status and `irq_o` after every pop. Ties and strict preemption are reached by raising two equal-priority lines in the same cycle and then retriggering a priority-7 source from software.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int BUS_W = 32;
  localparam int ADR_W = 8;

  localparam logic [ADR_W-1:0] A_SEL  = 8'h00;
  localparam logic [ADR_W-1:0] A_MODE = 8'h04;
  localparam logic [ADR_W-1:0] A_SVEC = 8'h08;
  localparam logic [ADR_W-1:0] A_IVEC = 8'h10;
  localparam logic [ADR_W-1:0] A_STAT = 8'h18;
  localparam logic [ADR_W-1:0] A_MASK = 8'h30;
  localparam logic [ADR_W-1:0] A_EOI  = 8'h38;
  localparam logic [ADR_W-1:0] A_SPUR = 8'h3C;
  localparam logic [ADR_W-1:0] A_EN   = 8'h40;
  localparam logic [ADR_W-1:0] A_DIS  = 8'h44;
  localparam logic [ADR_W-1:0] A_CLR  = 8'h48;
  localparam logic [ADR_W-1:0] A_SET  = 8'h4C;

  localparam int MODE_EDGE_BIT = 4;

  typedef struct packed {
    logic en;
    logic dis;
    logic set;
    logic clr;
    logic wr_mode;
    logic wr_vec;
  } src_cmd_t;
endpackage

// File: rtl/ivc_src_bank.sv
module ivc_src_bank
  import ivc_pkg::*;
#(
  parameter int N_SRC  = 128,
  parameter int PRIO_W = 3,
  parameter int VEC_W  = 32,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_SRC-1:0]              src_i,
  input  src_cmd_t                      cmd_i,
  input  logic [SEL_W-1:0]              sel_i,
  input  logic [BUS_W-1:0]              wdata_i,
  input  logic                          ack_i,
  input  logic [SEL_W-1:0]              ack_id_i,
  output logic [N_SRC-1:0]              req_o,
  output logic [N_SRC-1:0]              en_o,
  output logic [N_SRC-1:0]              edge_o,
  output logic [N_SRC-1:0][PRIO_W-1:0]  prio_o,
  output logic [N_SRC-1:0][VEC_W-1:0]   vec_o
);
  logic [N_SRC-1:0] src_q, pend_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic hit, rise, took;
    assign hit  = (sel_i == SEL_W'(g));
    assign rise = src_i[g] & ~src_q[g];
    assign took = ack_i && (ack_id_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q[g]  <= 1'b0;
        pend_q[g] <= 1'b0;
        en_o[g]   <= 1'b0;
        edge_o[g] <= 1'b0;
        prio_o[g] <= '0;
        vec_o[g]  <= '0;
      end else begin
        src_q[g] <= src_i[g];
        if (hit && cmd_i.en)  en_o[g] <= 1'b1;
        if (hit && cmd_i.dis) en_o[g] <= 1'b0;
        if (hit && cmd_i.wr_mode) begin
          prio_o[g] <= wdata_i[PRIO_W-1:0];
          edge_o[g] <= wdata_i[MODE_EDGE_BIT];
        end
        if (hit && cmd_i.wr_vec) vec_o[g] <= wdata_i[VEC_W-1:0];
        // a fresh edge or set wins over a same-cycle acknowledge
        if ((hit && cmd_i.set) || (edge_o[g] && rise)) pend_q[g] <= 1'b1;
        else if ((hit && cmd_i.clr) || took)            pend_q[g] <= 1'b0;
      end
    end

    assign req_o[g] = en_o[g] & (pend_q[g] | (~edge_o[g] & src_i[g]));
  end
endmodule

// File: rtl/ivc_pick.sv
module ivc_pick #(
  parameter int N_SRC  = 128,
  parameter int PRIO_W = 3,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]             req_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                         valid_o,
  output logic [SEL_W-1:0]             id_o,
  output logic [PRIO_W-1:0]            prio_o
);
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    prio_o  = '0;
    // strict compare keeps the lower index on a tie
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && (!valid_o || prio_i[i] > prio_o)) begin
        valid_o = 1'b1;
        id_o    = SEL_W'(i);
        prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/ivc_stack.sv
module ivc_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 7,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [ID_W-1:0]   id_i,
  output logic [CNT_W-1:0]  depth_o,
  output logic              empty_o,
  output logic [PRIO_W-1:0] top_prio_o,
  output logic [ID_W-1:0]   top_id_o
);
  logic [DEPTH-1:0][PRIO_W-1:0] prio_q;
  logic [DEPTH-1:0][ID_W-1:0]   id_q;
  logic [IDX_W-1:0]             wr_idx, top_idx;

  assign wr_idx  = IDX_W'(depth_o);
  assign top_idx = IDX_W'(depth_o - CNT_W'(1));
  assign empty_o = (depth_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_o <= '0;
      prio_q  <= '0;
      id_q    <= '0;
    end else if (push_i && depth_o != CNT_W'(DEPTH)) begin
      prio_q[wr_idx] <= prio_i;
      id_q[wr_idx]   <= id_i;
      depth_o        <= depth_o + CNT_W'(1);
    end else if (pop_i && !empty_o) begin
      depth_o <= depth_o - CNT_W'(1);
    end
  end

  assign top_prio_o = prio_q[top_idx];
  assign top_id_o   = id_q[top_idx];
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import ivc_pkg::*;
#(
  parameter int N_SRC       = 128,
  parameter int PRIO_W      = 3,
  parameter int VEC_W       = 32,
  parameter int STACK_DEPTH = 8,
  localparam int SEL_W   = $clog2(N_SRC),
  localparam int DEPTH_W = $clog2(STACK_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [7:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             irq_o
);
  logic                         wr, rd;
  logic [SEL_W-1:0]             sel_q;
  logic [BUS_W-1:0]             spur_q, rd_val, mode_rd;
  src_cmd_t                     cmd;
  logic [N_SRC-1:0]             req, en, edge_md;
  logic [N_SRC-1:0][PRIO_W-1:0] prio;
  logic [N_SRC-1:0][VEC_W-1:0]  vec;
  logic                         win_vld, cand, push, pop, empty;
  logic [SEL_W-1:0]             win_id, top_id;
  logic [PRIO_W-1:0]            win_prio, top_prio;
  logic [DEPTH_W-1:0]           depth;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  assign cmd.en      = wr && addr_i == A_EN   && wdata_i[0];
  assign cmd.dis     = wr && addr_i == A_DIS  && wdata_i[0];
  assign cmd.set     = wr && addr_i == A_SET  && wdata_i[0];
  assign cmd.clr     = wr && addr_i == A_CLR  && wdata_i[0];
  assign cmd.wr_mode = wr && addr_i == A_MODE;
  assign cmd.wr_vec  = wr && addr_i == A_SVEC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      spur_q <= '0;
    end else begin
      if (wr && addr_i == A_SEL)  sel_q  <= wdata_i[SEL_W-1:0];
      if (wr && addr_i == A_SPUR) spur_q <= wdata_i;
    end
  end

  ivc_src_bank #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_bank (
    .clk_i, .rst_ni, .src_i, .cmd_i(cmd), .sel_i(sel_q), .wdata_i,
    .ack_i(push), .ack_id_i(win_id), .req_o(req), .en_o(en),
    .edge_o(edge_md), .prio_o(prio), .vec_o(vec)
  );

  ivc_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_pick (
    .req_i(req), .prio_i(prio), .valid_o(win_vld), .id_o(win_id), .prio_o(win_prio)
  );

  ivc_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W), .ID_W(SEL_W)) u_stack (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop), .prio_i(win_prio), .id_i(win_id),
    .depth_o(depth), .empty_o(empty), .top_prio_o(top_prio), .top_id_o(top_id)
  );

  assign cand  = win_vld && (empty || win_prio > top_prio);
  assign irq_o = cand;
  assign push  = rd && addr_i == A_IVEC && cand;
  assign pop   = wr && addr_i == A_EOI;

  always_comb begin
    mode_rd                = '0;
    mode_rd[PRIO_W-1:0]    = prio[sel_q];
    mode_rd[MODE_EDGE_BIT] = edge_md[sel_q];
  end

  always_comb begin
    unique case (addr_i)
      A_SEL:   rd_val = BUS_W'(sel_q);
      A_MODE:  rd_val = mode_rd;
      A_SVEC:  rd_val = BUS_W'(vec[sel_q]);
      A_IVEC:  rd_val = cand ? BUS_W'(vec[win_id]) : spur_q;
      A_STAT:  rd_val = empty ? '0 : {1'b1, (BUS_W - 1)'(top_id)};
      A_MASK:  rd_val = BUS_W'(en[sel_q]);
      A_SPUR:  rd_val = spur_q;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_val;
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int N_SRC       = 128,
  parameter int STACK_DEPTH = 8,
  parameter int DEPTH_W     = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [7:0]         addr_i,
  input logic               irq_o,
  input logic [DEPTH_W-1:0] depth_i,
  input logic [N_SRC-1:0]   en_i
);
  logic ivec_rd, eoi_wr;
  assign ivec_rd = req_i && !we_i && addr_i == 8'h10;
  assign eoi_wr  = req_i && we_i && addr_i == 8'h38;

  // R11
  stack_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_i <= DEPTH_W'(STACK_DEPTH));

  // R7
  push_on_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ivec_rd && irq_o) |=> depth_i == $past(depth_i) + DEPTH_W'(1));

  // R8
  spurious_keeps_stack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ivec_rd && !irq_o) |=> $stable(depth_i));

  // R9
  eoi_pops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_wr && depth_i != '0) |=> depth_i == $past(depth_i) - DEPTH_W'(1));

  // R11
  eoi_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_wr && depth_i == '0) |=> depth_i == '0);

  // R3
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> !irq_o);
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
  .N_SRC(N_SRC), .STACK_DEPTH(STACK_DEPTH), .DEPTH_W(DEPTH_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .irq_o(irq_o), .depth_i(depth), .en_i(en)
);

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] src = '0;
  logic         req = 1'b0, we = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0, rdata_o;
  logic         irq;
  int           checks = 0, errors = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o), .irq_o(irq)
  );

  typedef struct packed {
    logic [6:0]  src;
    logic [7:0]  mode;
    logic [31:0] vec;
  } row_t;

  // R5 table: mode keeps bits [2:0] and 4 only
  localparam row_t TBL [6] = '{
    '{7'd3,   8'h02, 32'h0000_0300},
    '{7'd10,  8'h15, 32'h0000_0A00},
    '{7'd20,  8'h05, 32'h0000_1400},
    '{7'd127, 8'h17, 32'h0000_7F00},
    '{7'd0,   8'hEF, 32'hCAFE_0000},
    '{7'd64,  8'h11, 32'h0000_4000}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata_o;
  endtask

  task automatic rd_chk(input string r, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(r, d, exp);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd_chk("R1 status", 8'h18, 32'h0);
    rd_chk("R1 mask", 8'h30, 32'h0);
    rd_chk("R1 spurious", 8'h3C, 32'h0);
    rd_chk("R1 ivec", 8'h10, 32'h0);

    // R5 R2 table walk: program every row, then read each back
    foreach (TBL[i]) begin
      wr(8'h00, 32'(TBL[i].src));
      wr(8'h04, 32'(TBL[i].mode));
      wr(8'h08, TBL[i].vec);
    end
    foreach (TBL[i]) begin
      wr(8'h00, 32'(TBL[i].src));
      rd_chk("R5 mode", 8'h04, 32'(TBL[i].mode & 8'h17));
      rd_chk("R5 vector", 8'h08, TBL[i].vec);
    end

    // R8 spurious word
    wr(8'h3C, 32'hDEAD_BEEF);
    rd_chk("R8 spurious ivec", 8'h10, 32'hDEAD_BEEF);

    // R3 R2 enable acts on selected source only
    wr(8'h00, 32'd10); wr(8'h40, 32'h1);
    rd_chk("R3 mask on", 8'h30, 32'h1);
    wr(8'h00, 32'd11);
    rd_chk("R2 neighbour mask", 8'h30, 32'h0);

    // R4 pending while disabled, then enabled
    wr(8'h00, 32'd3); wr(8'h4C, 32'h1);
    chk("R4 disabled pending quiet", {31'b0, irq}, 32'h0);
    wr(8'h40, 32'h1);
    chk("R4 enabled raises", {31'b0, irq}, 32'h1);
    rd_chk("R7 vector src3", 8'h10, 32'h0000_0300);
    rd_chk("R7 status src3", 8'h18, 32'h8000_0003);
    chk("R10 level ack cleared", {31'b0, irq}, 32'h0);
    wr(8'h38, 32'h0);
    rd_chk("R8 empty ivec", 8'h10, 32'hDEAD_BEEF);
    rd_chk("R7 status none", 8'h18, 32'h0);

    // R6 tie between 10 (edge) and 20 (level), both prio 5
    wr(8'h00, 32'd20); wr(8'h40, 32'h1);
    @(negedge clk); src[10] = 1'b1; src[20] = 1'b1;
    @(negedge clk);
    chk("R10 edge raises", {31'b0, irq}, 32'h1);
    rd_chk("R6 tie lower index", 8'h10, 32'h0000_0A00);
    rd_chk("R7 status src10", 8'h18, 32'h8000_000A);
    chk("R9 equal prio blocked", {31'b0, irq}, 32'h0);
    wr(8'h00, 32'd127); wr(8'h40, 32'h1); wr(8'h4C, 32'h1);
    chk("R9 higher preempts", {31'b0, irq}, 32'h1);
    rd_chk("R9 nested vector", 8'h10, 32'h0000_7F00);
    rd_chk("R9 nested status", 8'h18, 32'h8000_007F);
    wr(8'h38, 32'h0);
    rd_chk("R9 pop status", 8'h18, 32'h8000_000A);
    chk("R9 still blocked", {31'b0, irq}, 32'h0);
    wr(8'h38, 32'h0);
    chk("R9 empty raises", {31'b0, irq}, 32'h1);
    rd_chk("R10 edge cleared, level wins", 8'h10, 32'h0000_1400);
    @(negedge clk); src[10] = 1'b0; src[20] = 1'b0;
    @(negedge clk);
    wr(8'h38, 32'h0);
    chk("R10 level follows line", {31'b0, irq}, 32'h0);
    rd_chk("R7 status cleared", 8'h18, 32'h0);

    // R6 priority beats index; R4 clear command
    wr(8'h00, 32'd127); wr(8'h4C, 32'h1);
    wr(8'h00, 32'd3);   wr(8'h4C, 32'h1);
    rd_chk("R6 higher prio wins", 8'h10, 32'h0000_7F00);
    chk("R9 lower blocked", {31'b0, irq}, 32'h0);
    wr(8'h48, 32'h1);
    wr(8'h38, 32'h0);
    chk("R4 clear removes pending", {31'b0, irq}, 32'h0);
    wr(8'h44, 32'h1);
    rd_chk("R3 mask off", 8'h30, 32'h0);
    wr(8'h00, 32'd127); wr(8'h44, 32'h1);

    // R11 fill all eight levels with prio 0..7
    for (int k = 0; k < 8; k++) begin
      wr(8'h00, 32'(40 + k));
      wr(8'h04, 32'(k));
      wr(8'h08, 32'h100 + 32'(k));
      wr(8'h40, 32'h1);
      wr(8'h4C, 32'h1);
      rd_chk("R11 fill vector", 8'h10, 32'h100 + 32'(k));
    end
    rd_chk("R11 full status", 8'h18, 32'h8000_002F);
    wr(8'h00, 32'd40); wr(8'h4C, 32'h1);
    chk("R9 prio0 blocked when full", {31'b0, irq}, 32'h0);
    for (int j = 0; j < 7; j++) begin
      wr(8'h38, 32'h0);
      rd_chk("R11 unwind status", 8'h18, 32'h8000_0000 | 32'(46 - j));
      chk("R11 unwind irq", {31'b0, irq}, 32'h0);
    end
    wr(8'h38, 32'h0);
    rd_chk("R11 eighth pop empties", 8'h18, 32'h0);
    chk("R11 prio0 released", {31'b0, irq}, 32'h1);
    wr(8'h38, 32'h0);
    chk("R11 eoi on empty harmless", {31'b0, irq}, 32'h1);
    wr(8'h44, 32'h1);
    chk("R3 disable hides pending", {31'b0, irq}, 32'h0);
    wr(8'h40, 32'h1);
    rd_chk("R4 pending kept over disable", 8'h10, 32'h0000_0100);
    wr(8'h38, 32'h0);
    chk("R11 final idle", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule